// File: doc/BRIEF.md
# Cascadable Display Column Data Loader

This block is the digital input stage of a column driver for an active-matrix panel. Each enabled shift beat carries one 18-bit word holding three 6-bit gray codes for one red, green and blue triple. A position token moves through the device one triple at a time and steers each word into a row-wide data register. When a line-latch strobe arrives, the whole row moves into an output latch that feeds the per-channel converters, and the token chain is cleared.

Several devices can be chained. Two start pins each have an input, an output and an output enable. The direction input decides which pin receives the start token and which pin passes the carry on to the next device, and it also decides the fill order of the channels. A mode input selects 309 channels or 300 channels. In 300-channel mode the nine middle channels 151 to 159 are skipped, so the chain is shorter. On the board that input is pulled high, which selects 309 channels.

Top module: `col_loader`

## Requirements
- R1: While `rst_n` is low, every channel code in `ch_code` and both start-pin outputs are 0.
- R2: In an enabled beat, `pix_in[5:0]` goes to the lowest-numbered channel of the selected triple, `pix_in[11:6]` to the middle channel and `pix_in[17:12]` to the highest. Channel c (1-based) appears at `ch_code[(c-1)*6 +: 6]`, with bit 0 as the LSB.
- R3: With `dir_up` high, the token is taken from `sp1_in` on an enabled beat. That same beat loads channels 1-3, and each later enabled beat loads the next higher triple.
- R4: With `dir_up` low, the token is taken from `sp2_in`. The first beat loads channels 307-309, and each later beat loads the next lower triple.
- R5: The carry output is high from the edge at which the last triple is captured until the next enabled beat, which is exactly one shift beat. It appears on `sp2_out` when `dir_up` is high and on `sp1_out` when `dir_up` is low. The output enable is high only on that same pin, and the other start-pin output stays 0.
- R6: On a clock where `line_latch` is high, the data register is copied into `ch_code`. At all other times `ch_code` holds its value.
- R7: A strobe clears the token chain and drops any carry. After it, enabled beats load nothing until a new start pulse is seen. A strobe in the middle of a line latches the partial row.
- R8: With `full_mode` low, the chain has 100 triples and skips channels 151-159. The carry follows the 100th beat, and a latch writes 0 to channels 151-159.
- R9: Once the chain is full, data beats and start pulses are ignored until the next strobe.
- R10: A clock with `shift_en` low loads nothing, does not move the token, and leaves the carry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shift_en | input | 1 | Marks a clock as a shift beat |
| pix_in | input | 18 | Three 6-bit gray codes |
| dir_up | input | 1 | 1: ascending fill, 0: descending fill |
| full_mode | input | 1 | 1: 309 channels, 0: 300 channels |
| line_latch | input | 1 | Row latch strobe; also clears the token chain |
| sp1_in | input | 1 | Start pin 1, input side |
| sp1_out | output | 1 | Start pin 1, carry output |
| sp1_oe | output | 1 | Start pin 1, output enable |
| sp2_in | input | 1 | Start pin 2, input side |
| sp2_out | output | 1 | Start pin 2, carry output |
| sp2_oe | output | 1 | Start pin 2, output enable |
| ch_code | output | 1854 | Latched 6-bit code per channel |

## Verification
The assertions check, on every cycle, the following properties: the carry lasts exactly one beat, the outputs hold between strobes, a strobe drops the carry, the skipped channels are zero after a latch in 300-channel mode, and idle clocks leave the carry unchanged. Which triple each beat lands in can only be shown by the bench's scenarios, because that depends on the whole history of the line. The same applies to the reversed fill order, to ignored start pulses after a strobe or a full chain, and to partial lines. The bench compares every channel against a reference model after every clock, both for directed lines and for random lines with gaps and mode changes.

// File: rtl/col_loader.sv
module col_loader #(
  parameter int NCH        = 309,
  parameter int BW         = 6,
  parameter int SKIP_FIRST = 151,
  parameter int SKIP_CNT   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [3*BW-1:0]   pix_in,
  input  logic              dir_up,
  input  logic              full_mode,
  input  logic              line_latch,
  input  logic              sp1_in,
  output logic              sp1_out,
  output logic              sp1_oe,
  input  logic              sp2_in,
  output logic              sp2_out,
  output logic              sp2_oe,
  output logic [NCH*BW-1:0] ch_code
);
  localparam int GW     = 3 * BW;
  localparam int NGRP   = NCH / 3;
  localparam int SKG0   = (SKIP_FIRST - 1) / 3;
  localparam int SKGN   = SKIP_CNT / 3;
  localparam int NSHORT = NGRP - SKGN;
  localparam int PW     = $clog2(NGRP + 1);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] pos, n_used, asc, phys;
  logic active, full, carry, start, take, last;
  logic [NGRP-1:0][GW-1:0] dreg, lat_next;

  assign n_used = full_mode ? PW'(NGRP) : PW'(NSHORT);
  assign start  = dir_up ? sp1_in : sp2_in;
  assign take   = shift_en & ~line_latch & ~full & (active | start);
  assign last   = (pos == n_used - ONE);
  assign asc    = dir_up ? pos : n_used - ONE - pos;
  assign phys   = (!full_mode && asc >= PW'(SKG0)) ? asc + PW'(SKGN) : asc;

  assign sp1_oe  = ~dir_up;
  assign sp2_oe  = dir_up;
  assign sp1_out = carry & ~dir_up;
  assign sp2_out = carry & dir_up;

  for (genvar g = 0; g < NGRP; g++) begin : g_mask
    if (g >= SKG0 && g < SKG0 + SKGN) begin : g_skip
      assign lat_next[g] = full_mode ? dreg[g] : '0;
    end else begin : g_keep
      assign lat_next[g] = dreg[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
      active <= 1'b0;
      full <= 1'b0;
      carry <= 1'b0;
    end else if (line_latch) begin
      pos <= '0;
      active <= 1'b0;
      full <= 1'b0;
      carry <= 1'b0;
    end else if (shift_en) begin
      carry <= take & last;
      if (take) begin
        if (last) begin
          full <= 1'b1;
          active <= 1'b0;
          pos <= '0;
        end else begin
          active <= 1'b1;
          pos <= pos + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreg <= '0;
    else if (take) dreg[phys] <= pix_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_code <= '0;
    else if (line_latch) ch_code <= lat_next;
  end
endmodule

module col_loader_chk #(
  parameter int NCH        = 309,
  parameter int BW         = 6,
  parameter int SKIP_FIRST = 151,
  parameter int SKIP_CNT   = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_en,
  input logic              line_latch,
  input logic              full_mode,
  input logic              sp1_out,
  input logic              sp2_out,
  input logic [NCH*BW-1:0] ch_code
);
  logic co;
  assign co = sp1_out | sp2_out;

  p_carry_one_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && co) |=> !co);

  p_hold_between_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_latch |=> $stable(ch_code));

  p_strobe_drops_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_latch |=> !co);

  p_skip_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_latch && !full_mode) |=> (ch_code[(SKIP_FIRST-1)*BW +: SKIP_CNT*BW] == '0));

  p_idle_keeps_carry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !line_latch) |=> $stable(co));
endmodule

bind col_loader col_loader_chk #(.NCH(NCH), .BW(BW), .SKIP_FIRST(SKIP_FIRST), .SKIP_CNT(SKIP_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .line_latch(line_latch),
  .full_mode(full_mode), .sp1_out(sp1_out), .sp2_out(sp2_out), .ch_code(ch_code)
);

// File: tb/col_loader_test.sv
`timescale 1ns/1ps
module col_loader_test;
  localparam int NCH = 309;
  localparam int NG  = 103;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0, dir_up = 1'b1, full_mode = 1'b1, line_latch = 1'b0;
  logic sp1_in = 1'b0, sp2_in = 1'b0;
  logic [17:0] pix_in = '0;
  logic sp1_out, sp1_oe, sp2_out, sp2_oe;
  logic [NCH*6-1:0] ch_code;

  int errors = 0, checks = 0, cyc = 0;
  logic [17:0] m_dreg [0:NG-1];
  logic [NCH*6-1:0] m_olat = '0;
  int m_pos = 0;
  bit m_act = 0, m_full = 0, m_carry = 0;
  logic [17:0] pv [0:NG-1];
  logic [NCH*6-1:0] saved;

  always #5 clk = ~clk;

  col_loader uut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .pix_in(pix_in), .dir_up(dir_up),
    .full_mode(full_mode), .line_latch(line_latch), .sp1_in(sp1_in), .sp1_out(sp1_out),
    .sp1_oe(sp1_oe), .sp2_in(sp2_in), .sp2_out(sp2_out), .sp2_oe(sp2_oe), .ch_code(ch_code)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] chv(input int c1);
    return ch_code[(c1-1)*6 +: 6];
  endfunction

  task automatic chk_vec(input string tag);
    int bad = 0;
    for (int c = NCH; c >= 1; c--)
      if (ch_code[(c-1)*6 +: 6] !== m_olat[(c-1)*6 +: 6]) bad = c;
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s channel %0d: actual %0h expected %0h", tag, bad,
               ch_code[(bad-1)*6 +: 6], m_olat[(bad-1)*6 +: 6]);
    end
  endtask

  task automatic step(input bit en, input bit st, input logic [17:0] px, input bit lat);
    int n, k, g;
    bit take;
    shift_en = en; line_latch = lat; pix_in = px;
    sp1_in = dir_up & st; sp2_in = !dir_up & st;
    @(posedge clk); #2;
    n = full_mode ? 103 : 100;
    if (lat) begin
      for (int gg = 0; gg < NG; gg++)
        for (int s = 0; s < 3; s++) begin
          int c = 3*gg + s;
          logic [5:0] v = m_dreg[gg][6*s +: 6];
          if (!full_mode && c >= 150 && c < 159) v = '0;
          m_olat[c*6 +: 6] = v;
        end
      m_pos = 0; m_act = 0; m_full = 0; m_carry = 0;
    end else if (en) begin
      take = !m_full && (m_act || st);
      m_carry = take && (m_pos == n-1);
      if (take) begin
        k = dir_up ? m_pos : n-1-m_pos;
        g = (!full_mode && k >= 50) ? k+3 : k;
        m_dreg[g] = px;
        if (m_pos == n-1) begin m_full = 1; m_act = 0; m_pos = 0; end
        else begin m_act = 1; m_pos++; end
      end
    end
    shift_en = 0; line_latch = 0; sp1_in = 0; sp2_in = 0;
    chk(sp1_out == (m_carry && !dir_up) && sp2_out == (m_carry && dir_up) &&
        sp1_oe == !dir_up && sp2_oe == dir_up, "R5 start pins",
        {sp1_oe, sp1_out, sp2_oe, sp2_out},
        {!dir_up, m_carry && !dir_up, dir_up, m_carry && dir_up});
    chk_vec("R6 latched row");
  endtask

  task automatic line(input int nb);
    for (int i = 0; i < nb; i++) begin
      pv[i] = 18'($urandom);
      step(1, i == 0, pv[i], 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int g = 0; g < NG; g++) m_dreg[g] = '0;
    repeat (3) @(posedge clk);
    #2;
    chk(ch_code == '0 && !sp1_out && !sp2_out, "R1 reset state", {sp1_out, sp2_out}, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);

    // R3 / R2 ascending 309
    dir_up = 1; full_mode = 1;
    line(103);
    chk(sp2_out == 1 && sp1_out == 0, "R5 carry on pin 2", {sp1_out, sp2_out}, 2'b01);
    chk(ch_code == '0, "R6 no change before strobe", ch_code[63:0], 0);
    step(1, 1, 18'h3ffff, 0);
    chk(sp2_out == 0, "R9 carry gone, full chain ignores start", sp2_out, 0);
    step(0, 0, 0, 1);
    chk(chv(1) == pv[0][5:0], "R3 channel 1", chv(1), pv[0][5:0]);
    chk(chv(2) == pv[0][11:6], "R2 channel 2 middle code", chv(2), pv[0][11:6]);
    chk(chv(309) == pv[102][17:12], "R2 channel 309 high code", chv(309), pv[102][17:12]);

    // R4 descending 309
    dir_up = 0;
    line(103);
    chk(sp1_out == 1 && sp2_out == 0, "R5 carry on pin 1", {sp1_out, sp2_out}, 2'b10);
    step(0, 0, 0, 1);
    chk(chv(307) == pv[0][5:0], "R4 first beat to channel 307", chv(307), pv[0][5:0]);
    chk(chv(3) == pv[102][17:12], "R4 last beat to channel 3", chv(3), pv[102][17:12]);

    // R7 no load without a new start pulse
    saved = ch_code;
    for (int i = 0; i < 20; i++) step(1, 0, 18'($urandom), 0);
    step(0, 0, 0, 1);
    chk(ch_code == saved, "R7 no load before start", ch_code[63:0], saved[63:0]);

    // R7 partial line then strobe
    dir_up = 1;
    line(10);
    step(0, 0, 0, 1);
    chk(chv(1) == pv[0][5:0], "R7 partial row latched", chv(1), pv[0][5:0]);
    for (int i = 0; i < 5; i++) step(1, 0, 18'($urandom), 0);
    step(0, 0, 0, 1);
    chk(chv(1) == pv[0][5:0], "R7 chain cleared by strobe", chv(1), pv[0][5:0]);

    // R10 start pulse without shift beat
    saved = ch_code;
    for (int i = 0; i < 3; i++) step(0, 1, 18'($urandom), 0);
    for (int i = 0; i < 5; i++) step(1, 0, 18'($urandom), 0);
    step(0, 0, 0, 1);
    chk(ch_code == saved, "R10 idle start ignored", ch_code[63:0], saved[63:0]);

    // R8 300-channel ascending
    full_mode = 0; dir_up = 1;
    line(99);
    chk(sp2_out == 0, "R8 no carry at beat 99", sp2_out, 0);
    pv[99] = 18'($urandom);
    step(1, 0, pv[99], 0);
    chk(sp2_out == 1, "R8 carry after beat 100", sp2_out, 1);
    step(0, 0, 0, 1);
    chk(ch_code[150*6 +: 54] == '0, "R8 skipped channels zero", ch_code[150*6 +: 54], 0);
    chk(chv(160) == pv[50][5:0], "R8 beat 50 to channel 160", chv(160), pv[50][5:0]);
    chk(chv(309) == pv[99][17:12], "R8 last beat to channel 309", chv(309), pv[99][17:12]);

    // R8 300-channel descending
    dir_up = 0;
    line(100);
    step(0, 0, 0, 1);
    chk(chv(150) == pv[50][17:12], "R8 descending beat 50 to channel 150", chv(150), pv[50][17:12]);
    chk(chv(160) == pv[49][5:0], "R8 descending beat 49 to channel 160", chv(160), pv[49][5:0]);

    // random lines with gaps, stray starts and early strobes
    for (int l = 0; l < 12; l++) begin
      int nb = 60 + int'($urandom % 60);
      bit started = 0;
      dir_up = 1'($urandom); full_mode = 1'($urandom);
      for (int i = 0; i < nb; i++) begin
        bit en = ($urandom % 10) < 7;
        bit st = (!started && en) || (($urandom % 25) == 0);
        if (en && st) started = 1;
        step(en, st, 18'($urandom), 0);
      end
      step(0, 0, 0, 1);
    end

    summary();
    $finish;
  end
endmodule